// File: doc/BRIEF.md
# Slave Parallel Configuration Loader

This block loads a configuration image into a programmable target device through an 8-bit parallel slave port. It pulls the target's active-low reset-to-configure line low for a set number of system clocks and releases it. It then waits while the target holds its clear/status line low to wipe its configuration memory. Once that line returns high, the block streams image bytes onto an 8-bit bus, with one rising edge of a divided configuration clock per byte.

Bytes arrive from a valid/ready source that stands in for a host memory or a microcontroller. When the source stalls, the configuration clock stops low with the current byte held. After the last byte the clock keeps running until the target raises its configured line. A fixed number of further clocks then follows, and the block returns to idle with a success flag that holds until the next start. The status line falling at any point after clearing counts as an integrity (CRC) failure. Each waiting phase has its own time limit, and a phase code reports which limit expired.

Top module: `cfgld_loader`

## Requirements
- R1: After reset, tgt_reset_n is 1, tgt_clk is 0, src_ready is 0, and busy, load_ok, crc_err, timeout and fail_phase are all 0.
- R2: A start pulse in idle or after a failure clears load_ok, crc_err, timeout and fail_phase, raises busy, and drives tgt_reset_n low for exactly PROG_LOW_CYC system clocks.
- R3: While the target holds tgt_clr_n low during clearing, no byte is requested (src_ready 0) and tgt_clk stays low.
- R4: Exactly NUM_BYTES bytes are taken from the source and shown on tgt_data in source order. Each byte is given exactly one tgt_clk rising edge, and tgt_data does not change while tgt_clk is high.
- R5: Every tgt_clk high phase lasts exactly HALF_DIV system clocks.
- R6: While the source offers no byte, tgt_clk stays low, no rising edge is issued and tgt_data holds.
- R7: After the last byte, tgt_clk keeps toggling until tgt_cfg_ok is seen high. Exactly POST_CLKS more rising edges follow. The block then drops busy and raises load_ok, which stays high until the next start.
- R8: tgt_clr_n seen low during the data phase or the trailing-clock phase ends the load with crc_err=1, timeout=0, fail_phase=0 and busy=0.
- R9: On a timeout the block ends with timeout=1, crc_err=0 and busy=0, and fail_phase reports the phase. Code 1 means tgt_clr_n did not fall within INIT_FALL_TO clocks of release. Code 2 means it did not rise within INIT_RISE_TO clocks. Code 3 means tgt_cfg_ok did not rise within TRAIL_TO clocks after the last byte.
- R10: A load that follows a failed load completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a load (taken in idle or failed state) |
| src_valid | input | 1 | Source offers a byte |
| src_data | input | 8 | Offered image byte |
| src_ready | output | 1 | Loader takes the offered byte this cycle |
| tgt_clr_n | input | 1 | Target clear/status line, low while clearing or on integrity failure |
| tgt_cfg_ok | input | 1 | Target configured indication |
| tgt_reset_n | output | 1 | Active-low request to the target to clear and accept a new image |
| tgt_clk | output | 1 | Configuration clock to the target |
| tgt_data | output | 8 | Configuration byte bus |
| busy | output | 1 | A load is in progress |
| load_ok | output | 1 | Last load completed successfully |
| crc_err | output | 1 | Last load ended on an integrity failure |
| timeout | output | 1 | Last load ended on a phase time limit |
| fail_phase | output | 2 | Timed-out phase: 0 none, 1 clear not started, 2 clear not finished, 3 configured not raised |

## Verification
The assertions assume the source keeps src_data steady while src_valid is high and src_ready is low. The bench holds each offered byte until it is taken. They also assume the target lines change only on system clock edges. The bench's target model updates tgt_clr_n and tgt_cfg_ok from registered logic on the rising edge and sees each tgt_clk rise one system clock late. HALF_DIV is kept at 2 or more so the model samples the byte while the clock is still high. Source availability is drawn at random per cycle from a fixed seed, with a directed long stall and directed target misbehaviour for each failure phase.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WFALL,
        ST_WRISE,
        ST_SEND,
        ST_TRAIL,
        ST_POST,
        ST_FAIL
    } ld_state_t;

    typedef enum logic [1:0] {
        PH_NONE        = 2'd0,
        PH_CLEAR_START = 2'd1,
        PH_CLEAR_END   = 2'd2,
        PH_TRAIL       = 2'd3
    } fail_phase_t;

    typedef struct packed {
        logic        ok;
        logic        crc;
        logic        tmo;
        fail_phase_t phase;
    } ld_status_t;

    function automatic int unsigned width_for(int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic clocking_state(ld_state_t s);
        return (s == ST_SEND) || (s == ST_TRAIL) || (s == ST_POST);
    endfunction

    function automatic ld_status_t tmo_status(fail_phase_t p);
        ld_status_t s;
        s.ok    = 1'b0;
        s.crc   = 1'b0;
        s.tmo   = 1'b1;
        s.phase = p;
        return s;
    endfunction

    function automatic ld_status_t crc_status();
        ld_status_t s;
        s.ok    = 1'b0;
        s.crc   = 1'b1;
        s.tmo   = 1'b0;
        s.phase = PH_NONE;
        return s;
    endfunction

    function automatic ld_status_t ok_status();
        ld_status_t s;
        s.ok    = 1'b1;
        s.crc   = 1'b0;
        s.tmo   = 1'b0;
        s.phase = PH_NONE;
        return s;
    endfunction

endpackage

// File: rtl/cfgld_divider.sv
module cfgld_divider #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign tick = en;
        end else begin : g_count
            localparam int unsigned CW = $clog2(HALF_DIV);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !en) begin
                    cnt <= '0;
                end else if (cnt == CW'(HALF_DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = en && (cnt == CW'(HALF_DIV - 1));

            // R5: half periods never collapse to one system clock
            assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/cfgld_phase_timer.sv
module cfgld_phase_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfgld_byte_feed.sv
module cfgld_byte_feed #(
    parameter int unsigned NUM_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       active,
    input  logic       line_low,
    input  logic       drop,
    input  logic       src_valid,
    input  logic [7:0] src_data,
    output logic       src_ready,
    output logic       held,
    output logic [7:0] data
);
    localparam int unsigned CW = cfgld_pkg::width_for(NUM_BYTES);

    logic [CW-1:0] taken;

    assign src_ready = active && line_low && !held && (taken < CW'(NUM_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            taken <= '0;
            held  <= 1'b0;
            data  <= '0;
        end else if (restart) begin
            taken <= '0;
            held  <= 1'b0;
        end else begin
            if (drop) begin
                held <= 1'b0;
            end
            if (src_ready && src_valid) begin
                data  <= src_data;
                held  <= 1'b1;
                taken <= taken + 1'b1;
            end
        end
    end

    // R6: a held byte stays on the bus until its clock pulse has finished
    assert_hold_data_R6: assert property (@(posedge clk) disable iff (rst)
        (held && !drop && !restart) |=> (held && $stable(data)));

    // R4: never more bytes taken than the image length
    assert_take_limit_R4: assert property (@(posedge clk) disable iff (rst)
        taken <= CW'(NUM_BYTES));
endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader #(
    parameter int unsigned NUM_BYTES    = 4096,
    parameter int unsigned HALF_DIV     = 4,
    parameter int unsigned PROG_LOW_CYC = 16,
    parameter int unsigned INIT_FALL_TO = 1000,
    parameter int unsigned INIT_RISE_TO = 50000,
    parameter int unsigned TRAIL_TO     = 20000,
    parameter int unsigned POST_CLKS    = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       src_valid,
    input  logic [7:0] src_data,
    output logic       src_ready,
    input  logic       tgt_clr_n,
    input  logic       tgt_cfg_ok,
    output logic       tgt_reset_n,
    output logic       tgt_clk,
    output logic [7:0] tgt_data,
    output logic       busy,
    output logic       load_ok,
    output logic       crc_err,
    output logic       timeout,
    output logic [1:0] fail_phase
);
    import cfgld_pkg::*;

    localparam int unsigned TMR_MAX = max3(max3(PROG_LOW_CYC, INIT_FALL_TO, INIT_RISE_TO), TRAIL_TO, 2);
    localparam int unsigned TMR_W   = width_for(TMR_MAX);
    localparam int unsigned CNT_W   = width_for(NUM_BYTES);
    localparam int unsigned PST_W   = width_for(POST_CLKS);

    ld_state_t  state, state_d;
    ld_status_t stat, stat_d;

    logic [TMR_W-1:0] tmr_cnt;
    logic [CNT_W-1:0] sent;
    logic [PST_W-1:0] post_cnt;
    logic             tick;
    logic             held;
    logic             fall_now;

    cfgld_divider #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (clocking_state(state)),
        .tick (tick)
    );

    cfgld_phase_timer #(.W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .clear (state_d != state),
        .cnt   (tmr_cnt)
    );

    assign fall_now = (state == ST_SEND) && tick && tgt_clk;

    cfgld_byte_feed #(.NUM_BYTES(NUM_BYTES)) u_feed (
        .clk       (clk),
        .rst       (rst),
        .restart   (state == ST_PROG),
        .active    (state == ST_SEND),
        .line_low  (!tgt_clk),
        .drop      (fall_now),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .held      (held),
        .data      (tgt_data)
    );

    always_comb begin
        state_d = state;
        stat_d  = stat;
        case (state)
            ST_IDLE, ST_FAIL: begin
                if (start) begin
                    state_d = ST_PROG;
                    stat_d  = '0;
                end
            end
            ST_PROG: begin
                if (tmr_cnt == TMR_W'(PROG_LOW_CYC - 1)) state_d = ST_WFALL;
            end
            ST_WFALL: begin
                if (!tgt_clr_n) begin
                    state_d = ST_WRISE;
                end else if (tmr_cnt == TMR_W'(INIT_FALL_TO - 1)) begin
                    state_d = ST_FAIL;
                    stat_d  = tmo_status(PH_CLEAR_START);
                end
            end
            ST_WRISE: begin
                if (tgt_clr_n) begin
                    state_d = ST_SEND;
                end else if (tmr_cnt == TMR_W'(INIT_RISE_TO - 1)) begin
                    state_d = ST_FAIL;
                    stat_d  = tmo_status(PH_CLEAR_END);
                end
            end
            ST_SEND: begin
                if (!tgt_clr_n) begin
                    state_d = ST_FAIL;
                    stat_d  = crc_status();
                end else if (sent == CNT_W'(NUM_BYTES) && !tgt_clk) begin
                    state_d = ST_TRAIL;
                end
            end
            ST_TRAIL: begin
                if (!tgt_clr_n) begin
                    state_d = ST_FAIL;
                    stat_d  = crc_status();
                end else if (tgt_cfg_ok) begin
                    state_d = ST_POST;
                end else if (tmr_cnt == TMR_W'(TRAIL_TO - 1)) begin
                    state_d = ST_FAIL;
                    stat_d  = tmo_status(PH_TRAIL);
                end
            end
            ST_POST: begin
                if (!tgt_clr_n) begin
                    state_d = ST_FAIL;
                    stat_d  = crc_status();
                end else if (post_cnt == PST_W'(POST_CLKS) && !tgt_clk) begin
                    state_d = ST_IDLE;
                    stat_d  = ok_status();
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            stat     <= '0;
            tgt_clk  <= 1'b0;
            sent     <= '0;
            post_cnt <= '0;
        end else begin
            state <= state_d;
            stat  <= stat_d;
            if (state == ST_PROG) sent <= '0;
            if (state != ST_POST) post_cnt <= '0;
            case (state)
                ST_SEND: begin
                    if (tick) begin
                        if (tgt_clk) begin
                            tgt_clk <= 1'b0;
                        end else if (held) begin
                            tgt_clk <= 1'b1;
                            sent    <= sent + 1'b1;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) tgt_clk <= !tgt_clk;
                end
                ST_POST: begin
                    if (tick) begin
                        if (tgt_clk) begin
                            tgt_clk <= 1'b0;
                        end else if (post_cnt < PST_W'(POST_CLKS)) begin
                            tgt_clk  <= 1'b1;
                            post_cnt <= post_cnt + 1'b1;
                        end
                    end
                end
                default: tgt_clk <= 1'b0;
            endcase
        end
    end

    assign tgt_reset_n = (state != ST_PROG);
    assign busy        = (state != ST_IDLE) && (state != ST_FAIL);
    assign load_ok     = stat.ok;
    assign crc_err     = stat.crc;
    assign timeout     = stat.tmo;
    assign fail_phase  = stat.phase;

    // R4: the byte bus is frozen whenever the configuration clock is high
    assert_data_stable_high_R4: assert property (@(posedge clk) disable iff (rst)
        tgt_clk |-> $stable(tgt_data));

    // R3: no clocking and no byte request while the target is being told to clear
    assert_quiet_in_prog_R3: assert property (@(posedge clk) disable iff (rst)
        !tgt_reset_n |-> (!tgt_clk && !src_ready));

    // R8 / R9: at most one outcome flag at a time
    assert_single_outcome_R8: assert property (@(posedge clk) disable iff (rst)
        $countones({load_ok, crc_err, timeout}) <= 1);

    // R9: a phase code only accompanies a timeout
    assert_phase_with_timeout_R9: assert property (@(posedge clk) disable iff (rst)
        (fail_phase != 2'd0) |-> timeout);

    // R7: success is only reported once the block is idle
    assert_ok_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        load_ok |-> !busy);

    // R2: the clear request is released only after its minimum width
    assert_prog_release_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tgt_reset_n) |-> (state == ST_WFALL));
endmodule

// File: tb/cfgld_loader_tb.sv
`timescale 1ns/1ps
module cfgld_loader_tb;
    localparam int NB  = 8;
    localparam int HD  = 2;
    localparam int PL  = 5;
    localparam int PC  = 3;
    localparam int IFT = 40;
    localparam int IRT = 150;
    localparam int TT  = 200;
    localparam int CLR = 20;
    localparam int TN  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       src_valid = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       src_ready;
    logic       tgt_clr_n;
    logic       tgt_cfg_ok;
    logic       tgt_reset_n;
    logic       tgt_clk;
    logic [7:0] tgt_data;
    logic       busy, load_ok, crc_err, timeout;
    logic [1:0] fail_phase;

    always #2.5 clk = ~clk;

    cfgld_loader #(
        .NUM_BYTES(NB), .HALF_DIV(HD), .PROG_LOW_CYC(PL),
        .INIT_FALL_TO(IFT), .INIT_RISE_TO(IRT), .TRAIL_TO(TT), .POST_CLKS(PC)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .tgt_clr_n(tgt_clr_n), .tgt_cfg_ok(tgt_cfg_ok),
        .tgt_reset_n(tgt_reset_n), .tgt_clk(tgt_clk), .tgt_data(tgt_data),
        .busy(busy), .load_ok(load_ok), .crc_err(crc_err), .timeout(timeout),
        .fail_phase(fail_phase)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    task automatic check(bit cond, string req, string what, int act, int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(int l, int i);
        return 8'((l * 37 + i * 53 + 90) ^ (i << 3));
    endfunction

    // ---------------- target model ----------------
    // mode: 0 normal, 1 clear never starts, 2 clear never ends,
    //       3 configured never rises, 4 fault in data phase, 5 fault in trailing phase
    int         mode = 0;
    logic       clr_m = 1'b1;
    logic       ok_m = 1'b0;
    logic       prev_clk = 1'b0;
    int         clr_left = 0;
    int         rise_cnt = 0;
    int         viol = 0;
    int         hi_w = 0;
    int         hi_min = 999;
    int         hi_max = 0;
    int         prog_w = 0;
    int         last_prog_w = 0;
    logic [7:0] cap [NB];

    assign tgt_clr_n  = clr_m;
    assign tgt_cfg_ok = ok_m;

    always @(posedge clk) begin
        prev_clk <= tgt_clk;
        if (tgt_clk) hi_w <= hi_w + 1;
        if (!tgt_clk && prev_clk) begin
            if (hi_w < hi_min) hi_min <= hi_w;
            if (hi_w > hi_max) hi_max <= hi_w;
            hi_w <= 0;
        end
        if (mode == 0 && !clr_m && (tgt_clk || src_ready)) viol <= viol + 1;
        if (rst) begin
            clr_m <= 1'b1;
            ok_m  <= 1'b0;
        end else if (!tgt_reset_n) begin
            prog_w   <= prog_w + 1;
            clr_m    <= (mode == 1);
            ok_m     <= 1'b0;
            rise_cnt <= 0;
            clr_left <= CLR;
        end else begin
            if (prog_w != 0) begin
                last_prog_w <= prog_w;
                prog_w      <= 0;
            end
            if (clr_left > 0) begin
                clr_left <= clr_left - 1;
                if (clr_left == 1 && mode != 2) clr_m <= 1'b1;
            end
            if (tgt_clk && !prev_clk) begin
                if (rise_cnt < NB) cap[rise_cnt] <= tgt_data;
                rise_cnt <= rise_cnt + 1;
                if (rise_cnt + 1 == NB + TN && mode != 3) ok_m <= 1'b1;
                if (mode == 4 && rise_cnt + 1 == 5) clr_m <= 1'b0;
                if (mode == 5 && rise_cnt + 1 == NB + 2) clr_m <= 1'b0;
            end
        end
    end

    // ---------------- byte source ----------------
    bit src_en = 0;
    bit stall = 0;
    bit fire = 0;
    int load_id = 0;
    int sidx = 0;
    int vprob = 100;

    initial begin
        forever begin
            @(negedge clk);
            if (fire) sidx = sidx + 1;
            fire = 0;
            if (src_en && !stall && sidx < NB && ($urandom % 100) < vprob) begin
                src_valid = 1'b1;
                src_data  = byte_of(load_id, sidx);
            end else begin
                src_valid = 1'b0;
                src_data  = 8'($urandom);
            end
            #1 fire = src_valid && src_ready;
        end
    end

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 8000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic begin_load(int m, int prob);
        @(negedge clk);
        mode    = m;
        load_id = load_id + 1;
        sidx    = 0;
        vprob   = prob;
        hi_min  = 999;
        hi_max  = 0;
        viol    = 0;
        src_en  = 1;
        #1 start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!tgt_reset_n && busy && !load_ok && !crc_err && !timeout, "R2",
              "start clears status and requests clear", {tgt_reset_n, busy, load_ok, crc_err, timeout}, 5'b01000);
    endtask

    task automatic check_success(string tag);
        int bad = 0;
        for (int i = 0; i < NB; i++) if (cap[i] !== byte_of(load_id, i)) bad++;
        check(load_ok && !crc_err && !timeout && !busy, "R7", {tag, " success status"},
              {load_ok, crc_err, timeout, busy}, 4'b1000);
        check(bad == 0, "R4", {tag, " bytes in order"}, bad, 0);
        check(sidx == NB, "R4", {tag, " bytes taken"}, sidx, NB);
        check(rise_cnt == NB + TN + PC, "R7", {tag, " total rising edges"}, rise_cnt, NB + TN + PC);
        check(last_prog_w == PL, "R2", {tag, " clear request width"}, last_prog_w, PL);
        check(hi_min == HD && hi_max == HD, "R5", {tag, " high phase width"}, hi_max * 1000 + hi_min, HD * 1000 + HD);
        check(viol == 0, "R3", {tag, " quiet while clearing"}, viol, 0);
    endtask

    task automatic check_fail(string req, string tag, bit crc, bit tmo, int ph);
        check(crc_err == crc && timeout == tmo && fail_phase == 2'(ph) && !load_ok && !busy, req, tag,
              {load_ok, crc_err, timeout, busy, fail_phase}, {1'b0, crc, tmo, 1'b0, 2'(ph)});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(tgt_reset_n && !tgt_clk && !src_ready && !busy && !load_ok && !crc_err && !timeout && fail_phase == 0,
              "R1", "reset outputs", {tgt_reset_n, tgt_clk, src_ready, busy, load_ok, crc_err, timeout}, 7'b1000000);

        // directed full-rate load
        begin_load(0, 100);
        wait_idle();
        check_success("full rate");
        repeat (30) @(negedge clk);
        check(load_ok && !busy, "R7", "success held while idle", {load_ok, busy}, 2'b10);

        // random source availability
        for (int k = 0; k < 4; k++) begin
            begin_load(0, 25 + 18 * k);
            wait_idle();
            check_success("random");
        end

        // R6: long stall in the middle of the image
        begin
            int rc;
            int bad_clk = 0;
            bit dstable = 1;
            logic [7:0] dh;
            begin_load(0, 100);
            while (sidx < 3) @(negedge clk);
            stall = 1;
            repeat (12) @(negedge clk);
            rc = rise_cnt;
            dh = tgt_data;
            for (int c = 0; c < 25; c++) begin
                @(negedge clk);
                if (tgt_clk) bad_clk++;
                if (tgt_data !== dh) dstable = 0;
            end
            check(bad_clk == 0, "R6", "clock low during stall", bad_clk, 0);
            check(rise_cnt == rc, "R6", "no edge during stall", rise_cnt, rc);
            check(dstable, "R6", "data held during stall", dstable, 1);
            stall = 0;
            wait_idle();
            check_success("after stall");
        end

        begin_load(1, 100);
        wait_idle();
        check_fail("R9", "clear never started", 0, 1, 1);

        begin_load(2, 100);
        wait_idle();
        check_fail("R9", "clear never finished", 0, 1, 2);

        begin_load(3, 100);
        wait_idle();
        check_fail("R9", "configured never raised", 0, 1, 3);

        begin_load(4, 100);
        wait_idle();
        check_fail("R8", "fault in data phase", 1, 0, 0);

        begin_load(5, 100);
        wait_idle();
        check_fail("R8", "fault in trailing phase", 1, 0, 0);

        // R10: recovery after a failure
        begin_load(0, 70);
        wait_idle();
        check_success("R10 recovery");

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog all: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule